// File: doc/BRIEF.md
# Half to Single Precision Converter

This block widens a 16-bit binary16 floating-point code into the equivalent 32-bit single-precision code. One code is accepted per clock under an input valid strobe, and the converted word appears on a registered output together with its own valid strobe one clock later. Every binary16 value has an exact single-precision image, so no rounding takes place. Zeros keep their sign. Subnormal halves are renormalised into single-precision normals. Infinities pass through, and NaNs keep their sign and payload.

A per-sample mode input selects how the all-ones half exponent is read. In the standard reading it encodes infinity and NaN. In the extended-range reading it is an ordinary exponent, so such codes reach magnitudes up to 131008. A signalling NaN converted in the standard reading raises a one-cycle invalid pulse that is aligned with its result.

Top module: `hp_to_sp_conv`

## Requirements
- R1: The input is read as sign in bit 15, biased exponent in bits 14:10 (offset 15) and fraction in bits 9:0. A half exponent of 1 to 30 gives output sign equal to bit 15, output exponent (bits 30:23) equal to the half exponent plus 112, and output fraction equal to the half fraction followed by 13 zero bits.
- R2: A zero exponent with a zero fraction gives a signed zero: 0x0000 gives 0x00000000 and 0x8000 gives 0x80000000.
- R3: A zero exponent with a nonzero fraction (value 2^-14 × 0.fraction) is converted exactly to a single-precision normal. 0x0001 gives 0x33800000 and 0x03FF gives 0x387FC000, and no output ever has a zero exponent with a nonzero fraction.
- R4: In standard mode (alt_mode = 0), an exponent of 31 with a zero fraction gives infinity: 0x7C00 gives 0x7F800000 and 0xFC00 gives 0xFF800000.
- R5: In standard mode, an exponent of 31 with a nonzero fraction gives a NaN. The output has the input sign, exponent 0xFF, and the input fraction shifted left by 13, with bit 22 (the quiet bit) forced to 1.
- R6: The invalid output is high for exactly the one cycle in which the result of a standard-mode signalling NaN (exponent 31, fraction nonzero, fraction bit 9 = 0) is presented. It is low for every other input and for every cycle without a new result.
- R7: In extended mode (alt_mode = 1), an exponent of 31 converts by the R1 rule. For example, 0x7FFF gives 0x47FFE000 (131008.0). All other codes convert exactly as in standard mode.
- R8: out_valid equals in_valid of the previous clock, and result and invalid belong to that same input.
- R9: A synchronous active-high reset clears out_valid, invalid and result to zero on the next clock.
- R10: In a cycle with in_valid low, result keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input code valid strobe |
| alt_mode | input | 1 | 1 = all-ones exponent is a normal exponent |
| half_in | input | 16 | binary16 input code |
| out_valid | output | 1 | Result valid, one clock after in_valid |
| result | output | 32 | Single-precision output code |
| invalid | output | 1 | Signalling NaN converted (standard mode) |

## Verification
Every output of this block (result, out_valid and invalid) is due exactly one rising edge after the edge that captures the input. Nothing is due earlier or later. The bench drives each code on a falling edge and checks the previous code's outputs on the next falling edge, half a period after the capturing edge. This lets a full sweep of all 65536 codes in both modes run back to back at one code per clock. For the hold and one-cycle-pulse checks, the bench idles in_valid and samples one falling edge later.

// File: rtl/hfp_pkg.sv
package hfp_pkg;
  typedef enum logic [2:0] {
    CLS_ZERO,
    CLS_SUB,
    CLS_NORM,
    CLS_INF,
    CLS_QNAN,
    CLS_SNAN
  } hcls_e;
endpackage

// File: rtl/hfp_classify.sv
module hfp_classify import hfp_pkg::*; #(
  parameter int EXP_W  = 5,
  parameter int FRAC_W = 10
) (
  input  logic [EXP_W+FRAC_W:0] code,
  input  logic                  alt_mode,
  output hcls_e                 cls,
  output logic                  sign,
  output logic [EXP_W-1:0]      exp_f,
  output logic [FRAC_W-1:0]     frac_f
);
  localparam logic [EXP_W-1:0] EXP_ONES = '1;

  assign sign   = code[EXP_W+FRAC_W];
  assign exp_f  = code[EXP_W+FRAC_W-1:FRAC_W];
  assign frac_f = code[FRAC_W-1:0];

  always_comb begin
    if (exp_f == '0)
      cls = (frac_f == '0) ? CLS_ZERO : CLS_SUB;
    else if (exp_f == EXP_ONES && !alt_mode) begin
      if (frac_f == '0)              cls = CLS_INF;
      else if (frac_f[FRAC_W-1])     cls = CLS_QNAN;
      else                           cls = CLS_SNAN;
    end else
      cls = CLS_NORM;
  end
endmodule

// File: rtl/hfp_lead_one.sv
module hfp_lead_one #(
  parameter int W     = 10,
  parameter int POS_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]     vec,
  output logic [POS_W-1:0] pos
);
  always_comb begin
    pos = '0;
    for (int i = 0; i < W; i++)
      if (vec[i]) pos = POS_W'(i);
  end

  // R3: the reported position is the highest set bit
  always_comb begin
    if (vec != '0)
      a_r3_lead_found: assert (vec[pos] && ((vec >> pos) == 1));
  end
endmodule

// File: rtl/hp_to_sp_conv.sv
module hp_to_sp_conv import hfp_pkg::*; #(
  parameter int IN_EXP_W   = 5,
  parameter int IN_FRAC_W  = 10,
  parameter int OUT_EXP_W  = 8,
  parameter int OUT_FRAC_W = 23
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              in_valid,
  input  logic                              alt_mode,
  input  logic [IN_EXP_W+IN_FRAC_W:0]       half_in,
  output logic                              out_valid,
  output logic [OUT_EXP_W+OUT_FRAC_W:0]     result,
  output logic                              invalid
);
  localparam int IN_BIAS  = (1 << (IN_EXP_W - 1)) - 1;
  localparam int OUT_BIAS = (1 << (OUT_EXP_W - 1)) - 1;
  localparam int GAP      = OUT_BIAS - IN_BIAS;
  localparam int SUB_BASE = GAP + 1 - IN_FRAC_W;
  localparam int PAD      = OUT_FRAC_W - IN_FRAC_W;
  localparam int POS_W    = $clog2(IN_FRAC_W);
  localparam logic [OUT_EXP_W-1:0] OUT_ONES = '1;

  hcls_e                 cls;
  logic                  h_sign;
  logic [IN_EXP_W-1:0]   h_exp;
  logic [IN_FRAC_W-1:0]  h_frac;
  logic [POS_W-1:0]      lead_pos;
  logic [POS_W:0]        shamt;
  logic [IN_FRAC_W-1:0]  sub_frac;
  logic [OUT_EXP_W-1:0]  norm_exp, sub_exp;
  logic [OUT_EXP_W+OUT_FRAC_W:0] nxt;

  hfp_classify #(.EXP_W(IN_EXP_W), .FRAC_W(IN_FRAC_W)) u_cls (
    .code(half_in), .alt_mode(alt_mode), .cls(cls),
    .sign(h_sign), .exp_f(h_exp), .frac_f(h_frac)
  );

  hfp_lead_one #(.W(IN_FRAC_W), .POS_W(POS_W)) u_lead (
    .vec(h_frac), .pos(lead_pos)
  );

  assign norm_exp = OUT_EXP_W'(h_exp) + OUT_EXP_W'(GAP);
  assign sub_exp  = OUT_EXP_W'(lead_pos) + OUT_EXP_W'(SUB_BASE);
  assign shamt    = (POS_W+1)'(IN_FRAC_W) - {1'b0, lead_pos};
  assign sub_frac = h_frac << shamt;

  always_comb begin
    case (cls)
      CLS_ZERO: nxt = {h_sign, {OUT_EXP_W{1'b0}}, {OUT_FRAC_W{1'b0}}};
      CLS_SUB:  nxt = {h_sign, sub_exp, sub_frac, {PAD{1'b0}}};
      CLS_INF:  nxt = {h_sign, OUT_ONES, {OUT_FRAC_W{1'b0}}};
      CLS_QNAN,
      CLS_SNAN: nxt = {h_sign, OUT_ONES, 1'b1, h_frac[IN_FRAC_W-2:0], {PAD{1'b0}}};
      default:  nxt = {h_sign, norm_exp, h_frac, {PAD{1'b0}}};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      invalid   <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      invalid   <= in_valid && (cls == CLS_SNAN);
      if (in_valid) result <= nxt;
    end
  end

  a_r8_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r8_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  a_r9_reset_clears: assert property (@(posedge clk)
    rst |=> (!out_valid && !invalid && result == '0));
  a_r6_invalid_with_result: assert property (@(posedge clk) disable iff (rst)
    invalid |-> out_valid);
  a_r6_no_invalid_alt: assert property (@(posedge clk) disable iff (rst)
    (in_valid && alt_mode) |=> !invalid);
  a_r3_no_denormal_out: assert property (@(posedge clk) disable iff (rst)
    (out_valid && result[OUT_EXP_W+OUT_FRAC_W-1:OUT_FRAC_W] == '0)
      |-> (result[OUT_FRAC_W-1:0] == '0));
  a_r5_nan_quiet: assert property (@(posedge clk) disable iff (rst)
    (out_valid && result[OUT_EXP_W+OUT_FRAC_W-1:OUT_FRAC_W] == OUT_ONES
      && result[OUT_FRAC_W-1:0] != '0) |-> result[OUT_FRAC_W-1]);
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result));
endmodule

// File: tb/tb_hp_to_sp_conv.sv
`timescale 1ns/1ps
module tb_hp_to_sp_conv;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        alt_mode = 1'b0;
  logic [15:0] half_in = '0;
  logic        out_valid;
  logic [31:0] result;
  logic        invalid;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  hp_to_sp_conv dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .alt_mode(alt_mode),
    .half_in(half_in), .out_valid(out_valid), .result(result), .invalid(invalid)
  );

  function automatic logic [31:0] ref_conv(input logic [15:0] h, input logic alt);
    logic [4:0]  e;
    logic [10:0] m;
    int          k;
    e = h[14:10];
    if (e == 0 && h[9:0] == 0) return {h[15], 31'd0};
    if (e == 0) begin
      m = {1'b0, h[9:0]};
      k = 0;
      while (!m[10]) begin m = m << 1; k++; end
      return {h[15], 8'(113 - k), m[9:0], 13'd0};
    end
    if (e == 31 && !alt) begin
      if (h[9:0] == 0) return {h[15], 8'hFF, 23'd0};
      return {h[15], 8'hFF, 1'b1, h[8:0], 13'd0};
    end
    return {h[15], 8'(int'(e) + 112), h[9:0], 13'd0};
  endfunction

  function automatic logic ref_snan(input logic [15:0] h, input logic alt);
    return !alt && h[14:10] == 5'h1F && h[9:0] != 0 && !h[9];
  endfunction

  function automatic string tag_of(input logic [15:0] h, input logic alt);
    if (h[14:10] == 0) return (h[9:0] == 0) ? "R2" : "R3";
    if (h[14:10] == 5'h1F) begin
      if (alt) return "R7";
      return (h[9:0] == 0) ? "R4" : "R5";
    end
    return "R1";
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic alt, input logic [15:0] h);
    @(negedge clk);
    in_valid = v; alt_mode = alt; half_in = h;
  endtask

  initial begin
    logic [15:0] prev_h;
    logic        prev_alt;
    logic        have_prev;
    repeat (3) @(negedge clk);
    chk("R9", {30'd0, out_valid, invalid}, 32'd0);
    chk("R9", result, 32'd0);
    rst = 1'b0;

    have_prev = 1'b0;
    prev_h = '0; prev_alt = 1'b0;
    for (int md = 0; md < 2; md++) begin
      for (int c = 0; c < 65536; c++) begin
        @(negedge clk);
        if (have_prev) begin
          chk(tag_of(prev_h, prev_alt), result, ref_conv(prev_h, prev_alt));
          chk("R6", {31'd0, invalid}, {31'd0, ref_snan(prev_h, prev_alt)});
          chk("R8", {31'd0, out_valid}, 32'd1);
        end
        in_valid = 1'b1; alt_mode = md[0]; half_in = c[15:0];
        prev_h = c[15:0]; prev_alt = md[0]; have_prev = 1'b1;
      end
    end
    drive(1'b0, 1'b0, 16'h0000);
    chk("R7", result, ref_conv(16'hFFFF, 1'b1));

    drive(1'b1, 1'b0, 16'h8000); drive(1'b0, 1'b0, 16'h0);
    chk("R2", result, 32'h80000000);
    drive(1'b1, 1'b0, 16'h0001); drive(1'b0, 1'b0, 16'h0);
    chk("R3", result, 32'h33800000);
    drive(1'b1, 1'b0, 16'h03FF); drive(1'b0, 1'b0, 16'h0);
    chk("R3", result, 32'h387FC000);
    drive(1'b1, 1'b0, 16'h7BFF); drive(1'b0, 1'b0, 16'h0);
    chk("R1", result, 32'h477FE000);
    drive(1'b1, 1'b1, 16'h7FFF); drive(1'b0, 1'b0, 16'h0);
    chk("R7", result, 32'h47FFE000);
    drive(1'b1, 1'b0, 16'hFC00); drive(1'b0, 1'b0, 16'h0);
    chk("R4", result, 32'hFF800000);
    drive(1'b1, 1'b0, 16'hFC01);
    drive(1'b0, 1'b1, 16'h1234);
    chk("R5", result, 32'hFFC02000);
    chk("R6", {31'd0, invalid}, 32'd1);
    drive(1'b0, 1'b0, 16'h3C00);
    chk("R6", {31'd0, invalid}, 32'd0);
    chk("R8", {31'd0, out_valid}, 32'd0);
    chk("R10", result, 32'hFFC02000);
    drive(1'b1, 1'b0, 16'h7C01);
    rst = 1'b1;
    @(negedge clk);
    chk("R9", {30'd0, out_valid, invalid}, 32'd0);
    chk("R9", result, 32'd0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule